// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-bit Timer Registers

This block sits between an 8-bit CPU bus and the 16-bit registers of a timer: the running counter, three compare registers and the capture register. Every 16-bit register takes two byte addresses, an even address for its low byte and the next odd address for its high byte. Each register sits at index `addr[AW-1:1]`: index 0 is the counter, indices 1 to NUM_CMP are the compare registers, and index NUM_CMP+1 is the capture register. All other indices are unmapped.

A single 8-bit holding byte is shared by every register. It makes the two byte halves of one 16-bit value move together. A write to a high-byte address fills only the holding byte. The following low-byte write then transfers the holding byte and the new low byte as one word in a single clock cycle. For reads, the low-byte access returns the low byte and, in the same cycle, captures the high byte into the holding byte. A later high-byte read returns that captured value, even if the source has moved on in the meantime.

Compare registers are stored inside the bridge, and their reads bypass the holding byte. The counter and the capture register live in the timer. The bridge gives the timer load strobes and a shared 16-bit load word for them, and it reads their live values.

Top module: `bbr_bridge16`

## Requirements
- R1: After reset the holding byte is 0x00 and every compare register is 0x0000. A high-byte read of the counter then returns 0x00.
- R2: A write to a mapped high-byte address (addr[0]=1) loads only the holding byte. It raises no load strobe and changes no compare register.
- R3: A write to the counter or capture low-byte address raises `cnt_ld` or `cap_ld` in that same cycle, with `ld_data` = {holding byte, written byte}. At most one of these strobes is high in any cycle.
- R4: A write to a compare low-byte address updates that compare register on the next clock edge to {holding byte, written byte}.
- R5: A low-byte read (addr[0]=0) returns bits [7:0] of the addressed register in the same cycle.
- R6: A low-byte read of the counter or capture register copies bits [15:8] of that register into the holding byte at the end of that cycle.
- R7: A high-byte read of the counter or capture register returns the holding byte and leaves the holding byte unchanged.
- R8: Reads of a compare register never change the holding byte. A compare high-byte read returns bits [15:8] of that compare register directly.
- R9: The holding byte is shared: a high byte written at one register's address is used by a later low-byte write to a different register.
- R10: A write to an unmapped address changes nothing, and a read of an unmapped address returns 0x00.
- R11: When `bus_rd` and `bus_wr` are both high, only the write takes effect and `bus_rdata` is 0x00.
- R12: `bus_rdata` is 0x00 in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address; bit 0 selects the high byte |
| bus_wdata | input | DW | Write byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Read byte, valid in the cycle of the read |
| cnt_val | input | 2*DW | Live counter value from the timer |
| cap_val | input | 2*DW | Live capture value from the timer |
| cnt_ld | output | 1 | Load strobe for the counter |
| cap_ld | output | 1 | Load strobe for the capture register |
| ld_data | output | 2*DW | Word to load with either strobe |
| cmp_vals | output | NUM_CMP*2*DW | Compare registers, compare 0 in the lowest bits |

## Verification
The hardest situation to reach is a high-byte read whose result must differ from the live value of the source. The counter value is therefore changed between the low-byte read and the high-byte read, and the bench expects the old high byte. Compare reads are interleaved with counter accesses after the holding byte has been set to a value different from the compare's high byte. This is the only way a port can tell a direct compare read apart from one that goes through the holding byte. The sharing rule is covered by writing a high byte at one register's address and then a low byte at another register's address.

// File: rtl/bbr_pkg.sv
`timescale 1ns/1ps
package bbr_pkg;
   typedef enum logic [1:0] {
      K_CNT  = 2'd0,
      K_CMP  = 2'd1,
      K_CAP  = 2'd2,
      K_NONE = 2'd3
   } kind_e;
endpackage

// File: rtl/bbr_decode.sv
`timescale 1ns/1ps
module bbr_decode
   import bbr_pkg::*;
#(
   parameter int AW      = 4,
   parameter int NUM_CMP = 3
) (
   input  logic [AW-1:0]      addr,
   output kind_e              kind,
   output logic               hi,
   output logic [NUM_CMP-1:0] cmp_sel
);
   localparam int RIW = AW - 1;
   localparam logic [RIW-1:0] CAP_IDX = RIW'(NUM_CMP + 1);

   logic [RIW-1:0] ridx;
   assign ridx = addr[AW-1:1];
   assign hi   = addr[0];

   for (genvar g = 0; g < NUM_CMP; g++) begin : g_sel
      localparam logic [RIW-1:0] MATCH = RIW'(g + 1);
      assign cmp_sel[g] = (ridx == MATCH);
   end

   always_comb begin
      if (ridx == '0)          kind = K_CNT;
      else if (|cmp_sel)       kind = K_CMP;
      else if (ridx == CAP_IDX) kind = K_CAP;
      else                     kind = K_NONE;
   end

   // R10: at most one compare register is selected, and none for another kind
   always_comb begin
      assert_sel_onehot_R10: assert ($onehot0(cmp_sel) && ((kind == K_CMP) == (|cmp_sel)));
   end
endmodule

// File: rtl/bbr_temp.sv
`timescale 1ns/1ps
module bbr_temp #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end

   // R7: the holding byte moves only when it is loaded
   assert_temp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q));
endmodule

// File: rtl/bbr_cmp_bank.sv
`timescale 1ns/1ps
module bbr_cmp_bank #(
   parameter int DW      = 8,
   parameter int NUM_CMP = 3,
   localparam int RW     = 2 * DW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CMP-1:0]    we,
   input  logic [RW-1:0]         wdata,
   input  logic [NUM_CMP-1:0]    rd_sel,
   output logic [NUM_CMP*RW-1:0] vals,
   output logic [RW-1:0]         rd_val
);
   logic [RW-1:0] q [NUM_CMP];

   for (genvar g = 0; g < NUM_CMP; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)     q[g] <= '0;
         else if (we[g]) q[g] <= wdata;
      end
      assign vals[g*RW +: RW] = q[g];

      // R4: a compare write lands on the next edge
      assert_cmp_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
         we[g] |=> (vals[g*RW +: RW] == $past(wdata)));
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_CMP; i++) begin
         rd_val = rd_val | (q[i] & {RW{rd_sel[i]}});
      end
   end
endmodule

// File: rtl/bbr_bridge16.sv
`timescale 1ns/1ps
module bbr_bridge16
   import bbr_pkg::*;
#(
   parameter int DW              = 8,
   parameter int AW              = 4,
   parameter int NUM_CMP         = 3,
   parameter bit CMP_READ_DIRECT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [AW-1:0]              bus_addr,
   input  logic [DW-1:0]              bus_wdata,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   output logic [DW-1:0]              bus_rdata,
   input  logic [2*DW-1:0]            cnt_val,
   input  logic [2*DW-1:0]            cap_val,
   output logic                       cnt_ld,
   output logic                       cap_ld,
   output logic [2*DW-1:0]            ld_data,
   output logic [NUM_CMP*2*DW-1:0]    cmp_vals
);
   localparam int RW = 2 * DW;

   if (DW < 1 || NUM_CMP < 1 || AW < 2 || (NUM_CMP + 2) > (1 << (AW - 1))) begin : g_bad_cfg
      $error("bbr_bridge16: address space too small for the register set");
   end

   kind_e              kind;
   logic               hi;
   logic [NUM_CMP-1:0] cmp_sel;
   logic [DW-1:0]      temp_q;
   logic [DW-1:0]      temp_d;
   logic               temp_ld;
   logic [RW-1:0]      cmp_rd;
   logic [RW-1:0]      live_src;
   logic [DW-1:0]      cmp_hi_byte;
   logic               cmp_rd_loads_temp;
   logic               rd_ok;
   logic               lo_wr;

   bbr_decode #(.AW(AW), .NUM_CMP(NUM_CMP)) u_dec (
      .addr(bus_addr), .kind(kind), .hi(hi), .cmp_sel(cmp_sel)
   );

   bbr_temp #(.DW(DW)) u_tmp (
      .clk(clk), .rst_n(rst_n), .ld(temp_ld), .d(temp_d), .q(temp_q)
   );

   assign rd_ok   = bus_rd & ~bus_wr;
   assign lo_wr   = bus_wr & ~hi;
   assign ld_data = {temp_q, bus_wdata};
   assign cnt_ld  = lo_wr & (kind == K_CNT);
   assign cap_ld  = lo_wr & (kind == K_CAP);

   bbr_cmp_bank #(.DW(DW), .NUM_CMP(NUM_CMP)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .we(cmp_sel & {NUM_CMP{lo_wr & (kind == K_CMP)}}),
      .wdata(ld_data), .rd_sel(cmp_sel),
      .vals(cmp_vals), .rd_val(cmp_rd)
   );

   assign live_src = (kind == K_CAP) ? cap_val : cnt_val;

   if (CMP_READ_DIRECT) begin : g_cmp_direct
      assign cmp_hi_byte       = cmp_rd[RW-1:DW];
      assign cmp_rd_loads_temp = 1'b0;
   end else begin : g_cmp_via_temp
      assign cmp_hi_byte       = temp_q;
      assign cmp_rd_loads_temp = 1'b1;
   end

   always_comb begin
      temp_ld = 1'b0;
      temp_d  = bus_wdata;
      if (bus_wr && hi && kind != K_NONE) begin
         temp_ld = 1'b1;
      end else if (rd_ok && !hi && (kind == K_CNT || kind == K_CAP)) begin
         temp_ld = 1'b1;
         temp_d  = live_src[RW-1:DW];
      end else if (rd_ok && !hi && kind == K_CMP && cmp_rd_loads_temp) begin
         temp_ld = 1'b1;
         temp_d  = cmp_rd[RW-1:DW];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_ok) begin
         unique case (kind)
            K_CNT, K_CAP: bus_rdata = hi ? temp_q : live_src[DW-1:0];
            K_CMP:        bus_rdata = hi ? cmp_hi_byte : cmp_rd[DW-1:0];
            default:      bus_rdata = '0;
         endcase
      end
   end

   // R3: the two timer load strobes never fire together
   assert_ld_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cnt_ld, cap_ld}));

   // R2: a mapped high-byte write lands in the holding byte only
   assert_hi_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[0] && kind != K_NONE) |-> (!cnt_ld && !cap_ld) ##1 (temp_q == $past(bus_wdata)));

   // R6: a counter low-byte read snapshots its high byte
   assert_lo_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok && !bus_addr[0] && kind == K_CNT) |=> (temp_q == $past(cnt_val[RW-1:DW])));
endmodule

// File: tb/sim_bbr_bridge16.sv
`timescale 1ns/1ps
module sim_bbr_bridge16;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [15:0] cnt_val = '0;
   logic [15:0] cap_val = '0;
   logic        cnt_ld;
   logic        cap_ld;
   logic [15:0] ld_data;
   logic [47:0] cmp_vals;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bbr_bridge16 u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .cnt_val(cnt_val), .cap_val(cap_val), .cnt_ld(cnt_ld), .cap_ld(cap_ld),
      .ld_data(ld_data), .cmp_vals(cmp_vals)
   );

   typedef struct packed {
      logic        rd;
      logic        wr;
      logic [3:0]  addr;
      logic [7:0]  wd;
      logic [15:0] cnt;
      logic [15:0] cap;
      logic [7:0]  erd;
      logic        ecl;
      logic        epl;
      logic [15:0] eld;
      logic [3:0]  req;
   } vec_t;

   // map: cnt 0/1, cmp0 2/3, cmp1 4/5, cmp2 6/7, cap 8/9, rest unmapped
   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b0,4'h1,8'h00,16'h1234,16'h0000,8'h00,1'b0,1'b0,16'h0000,4'd1},  // R1 reset temp
      '{1'b0,1'b1,4'h1,8'hAB,16'h0000,16'h0000,8'h00,1'b0,1'b0,16'h0000,4'd2},  // R2
      '{1'b0,1'b1,4'h0,8'hCD,16'h0000,16'h0000,8'h00,1'b1,1'b0,16'hABCD,4'd3},  // R3 counter
      '{1'b1,1'b0,4'h0,8'h00,16'h5678,16'h0000,8'h78,1'b0,1'b0,16'h0000,4'd5},  // R5
      '{1'b1,1'b0,4'h1,8'h00,16'h9999,16'h0000,8'h56,1'b0,1'b0,16'h0000,4'd6},  // R6 old high
      '{1'b1,1'b0,4'h1,8'h00,16'h9999,16'h0000,8'h56,1'b0,1'b0,16'h0000,4'd7},  // R7 repeat
      '{1'b0,1'b1,4'h9,8'h11,16'h0000,16'h0000,8'h00,1'b0,1'b0,16'h0000,4'd2},  // R2
      '{1'b0,1'b1,4'h8,8'h22,16'h0000,16'h0000,8'h00,1'b0,1'b1,16'h1122,4'd3},  // R3 capture
      '{1'b1,1'b0,4'h8,8'h00,16'h0000,16'hA5C3,8'hC3,1'b0,1'b0,16'h0000,4'd5},  // R5
      '{1'b1,1'b0,4'h9,8'h00,16'h0000,16'h0000,8'hA5,1'b0,1'b0,16'h0000,4'd6},  // R6
      '{1'b0,1'b1,4'h3,8'h3C,16'h0000,16'h0000,8'h00,1'b0,1'b0,16'h0000,4'd9},  // R9
      '{1'b0,1'b1,4'h6,8'h7E,16'h0000,16'h0000,8'h00,1'b0,1'b0,16'h0000,4'd9},  // R9 cmp2
      '{1'b1,1'b0,4'h0,8'h00,16'h0F01,16'h0000,8'h01,1'b0,1'b0,16'h0000,4'd6},  // R6
      '{1'b1,1'b0,4'h7,8'h00,16'h0000,16'h0000,8'h3C,1'b0,1'b0,16'h0000,4'd8},  // R8 direct
      '{1'b1,1'b0,4'h6,8'h00,16'h0000,16'h0000,8'h7E,1'b0,1'b0,16'h0000,4'd5},  // R5
      '{1'b1,1'b0,4'h1,8'h00,16'h0000,16'h0000,8'h0F,1'b0,1'b0,16'h0000,4'd8},  // R8 temp kept
      '{1'b0,1'b1,4'hA,8'h55,16'h0000,16'h0000,8'h00,1'b0,1'b0,16'h0000,4'd10}, // R10
      '{1'b1,1'b0,4'h1,8'h00,16'h0000,16'h0000,8'h0F,1'b0,1'b0,16'h0000,4'd10}, // R10
      '{1'b1,1'b0,4'hA,8'h00,16'hFFFF,16'hFFFF,8'h00,1'b0,1'b0,16'h0000,4'd10}, // R10
      '{1'b1,1'b1,4'h1,8'h66,16'h0000,16'h0000,8'h00,1'b0,1'b0,16'h0000,4'd11}, // R11
      '{1'b1,1'b0,4'h1,8'h00,16'h0000,16'h0000,8'h66,1'b0,1'b0,16'h0000,4'd11}, // R11
      '{1'b0,1'b0,4'h0,8'h00,16'h1111,16'h0000,8'h00,1'b0,1'b0,16'h0000,4'd12}  // R12
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic rd, input logic wr, input logic [3:0] a, input logic [7:0] d);
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 compares after reset", 64'(cmp_vals), 64'h0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i].rd, VEC[i].wr, VEC[i].addr, VEC[i].wd);
         cnt_val = VEC[i].cnt;
         cap_val = VEC[i].cap;
         #1;
         chk($sformatf("R%0d vec %0d rdata", VEC[i].req, i), 64'(bus_rdata), 64'(VEC[i].erd));
         chk($sformatf("R%0d vec %0d strobes", VEC[i].req, i), 64'({cnt_ld, cap_ld}),
             64'({VEC[i].ecl, VEC[i].epl}));
         if (VEC[i].ecl || VEC[i].epl)
            chk($sformatf("R%0d vec %0d ld_data", VEC[i].req, i), 64'(ld_data), 64'(VEC[i].eld));
      end

      // R9: shared holding byte went into compare 2; R10 unmapped write left all else alone
      @(negedge clk);
      drive(1'b0, 1'b0, 4'h0, 8'h00);
      #1;
      chk("R9 compare bank contents", 64'(cmp_vals), {16'h0, 16'h3C7E, 16'h0000, 16'h0000});

      // R2: high write to compare 0 does not reach the register
      @(negedge clk);
      drive(1'b0, 1'b1, 4'h3, 8'h99);
      #1;
      chk("R2 no strobe on high write", 64'({cnt_ld, cap_ld}), 64'h0);
      @(negedge clk);
      drive(1'b0, 1'b0, 4'h0, 8'h00);
      #1;
      chk("R2 compare 0 unchanged", 64'(cmp_vals[15:0]), 64'h0);

      // R4: compare 1 low write takes effect after the edge
      @(negedge clk);
      drive(1'b0, 1'b1, 4'h4, 8'h34);
      #1;
      chk("R4 compare 1 before edge", 64'(cmp_vals[31:16]), 64'h0);
      @(negedge clk);
      drive(1'b0, 1'b0, 4'h0, 8'h00);
      #1;
      chk("R4 compare 1 after edge", 64'(cmp_vals[31:16]), 64'h9934);
      chk("R4 other compares kept", 64'({cmp_vals[47:32], cmp_vals[15:0]}), 64'h3C7E_0000);

      // R1: reset in mid-run clears holding byte and compares
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 compares after second reset", 64'(cmp_vals), 64'h0);
      drive(1'b1, 1'b0, 4'h1, 8'h00);
      #1;
      chk("R1 holding byte after second reset", 64'(bus_rdata), 64'h0);
      @(negedge clk);
      drive(1'b0, 1'b0, 4'h0, 8'h00);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule